// File: doc/BRIEF.md
# Banked CPU Register File with Width Views and Name Aliasing

This block holds the general-purpose registers of a CPU core. There are several banks of sixteen byte-wide registers. A bank-select field inside the processor status word picks the bank for each access. The same storage can be read or written in three views:

- a single byte;
- a 16-bit pair of two neighbouring bytes, where the odd register is the high byte;
- a 24-bit value made of one of the upper four pairs plus a per-bank extension byte.

A legacy-compatibility input remaps four byte names and two pair names onto the low accumulator registers. Older code can then run against the same storage.

Reads are combinational from the bank the status word selects now. A write takes effect at the clock edge, into the bank selected in that cycle. An access whose width and index do not form a valid register has no effect on storage and raises an error flag.

Top module: `bank_regfile`

## Requirements
- R1: After reset every byte register and every extension byte in every bank reads 0, and the error flag is low for valid accesses.
- R2: Byte view (size code 2'b00): index n (0..15) selects register Rn of the active bank. Read data is {16'h0, Rn}. A write changes only Rn.
- R3: Pair view (size code 2'b01): index n (0..7) selects R(2n+1):R(2n). Read data is {8'h0, R(2n+1), R(2n)}. A write stores wr_data[15:8] in the odd byte and wr_data[7:0] in the even byte in one cycle, and ignores wr_data[23:16].
- R4: Extended view (size code 2'b10): index n (4..7) selects the extension byte E(n-4) on bits 23:16 and pair n on bits 15:0. A write updates all three bytes. Extension bytes are separate from R0..R15.
- R5: The active bank is bits 14:12 of the status word. The other status bits have no effect. Banks do not share storage.
- R6: With the compatibility input at 1, byte indices 4, 5, 6 and 7 access R0, R1, R2 and R3, and pair indices 2 and 3 access pairs 0 and 1. The extended view is unaffected.
- R7: A pair index above 7, an extended index outside 4..7, or size code 2'b11 drives the error flag high and read data to 0. A write with such an access changes no register.
- R8: A write goes to the bank and register selected in its own cycle. During that cycle the read data still shows the old contents. From the next cycle the new value is read back.
- R9: The views overlap. A byte written to R8..R15 appears inside the matching pair and extended values, and a pair write appears in both byte views.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_size | input | 2 | Access width: 00 byte, 01 pair, 10 extended, 11 invalid |
| acc_idx | input | 4 | Register, pair or extended index |
| wr_data | input | 24 | Write data, right-aligned |
| wr_en | input | 1 | Write strobe |
| status_word | input | 16 | Processor status word; bits 14:12 choose the bank |
| compat | input | 1 | Legacy name-aliasing enable |
| rd_data | output | 24 | Combinational read data, zero-extended |
| acc_err | output | 1 | Access does not name a valid register |

## Verification
A write and a combinational read of the same location fall in the same cycle.

The bench provokes this by holding a write's address, width and bank steady across the edge. It samples the read data once just before the edge and once just after. The first sample must show the stored old value and the second the freshly written one.

Aliasing is judged the same way: a value is written through one name and read back through its alias and through the other views.

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int NBANKS   = 8,
  parameter int BANK_LSB = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  acc_size,
  input  logic [3:0]  acc_idx,
  input  logic [23:0] wr_data,
  input  logic        wr_en,
  input  logic [15:0] status_word,
  input  logic        compat,
  output logic [23:0] rd_data,
  output logic        acc_err
);
  localparam int BW    = $clog2(NBANKS);
  localparam int NBYTE = NBANKS * 16;
  localparam int NEXT  = NBANKS * 4;

  logic [7:0] gpr [NBYTE];
  logic [7:0] ext [NEXT];

  logic [BW-1:0] bank;
  logic [2:0]    pair;
  logic [3:0]    byte_sel;
  logic [BW+3:0] a_lo, a_hi;
  logic [BW+1:0] a_ext;

  assign bank = status_word[BANK_LSB +: BW];

  assign acc_err = (acc_size == 2'b11) ||
                   (acc_size == 2'b01 && acc_idx[3]) ||
                   (acc_size == 2'b10 && (acc_idx[3] || !acc_idx[2]));

  assign byte_sel = (compat && acc_idx[3:2] == 2'b01) ? {2'b00, acc_idx[1:0]} : acc_idx;
  assign pair     = (compat && acc_size == 2'b01 && acc_idx[2:1] == 2'b01)
                    ? {2'b00, acc_idx[0]} : acc_idx[2:0];

  assign a_lo  = (acc_size == 2'b00) ? {bank, byte_sel} : {bank, pair, 1'b0};
  assign a_hi  = {bank, pair, 1'b1};
  assign a_ext = {bank, acc_idx[1:0]};

  always_comb begin
    rd_data = '0;
    if (!acc_err) begin
      case (acc_size)
        2'b00:   rd_data = {16'h0, gpr[a_lo]};
        2'b01:   rd_data = {8'h0, gpr[a_hi], gpr[a_lo]};
        default: rd_data = {ext[a_ext], gpr[a_hi], gpr[a_lo]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTE; i++) gpr[i] <= '0;
      for (int i = 0; i < NEXT; i++)  ext[i] <= '0;
    end else if (wr_en && !acc_err) begin
      gpr[a_lo] <= wr_data[7:0];
      if (acc_size != 2'b00) gpr[a_hi] <= wr_data[15:8];
      if (acc_size == 2'b10) ext[a_ext] <= wr_data[23:16];
    end
  end

  // R2
  p_byte_zero_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_size == 2'b00 |-> (rd_data[23:8] == 16'h0 && !acc_err));

  // R3
  p_pair_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_size == 2'b01 |-> rd_data[23:16] == 8'h0);

  // R7
  p_err_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> rd_data == 24'h0);

  // R8
  p_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && !acc_err) && $stable(acc_size) && $stable(acc_idx) &&
     $stable(bank) && $stable(compat))
    |-> (acc_size == 2'b00 ? rd_data[7:0]  == $past(wr_data[7:0]) :
         acc_size == 2'b01 ? rd_data[15:0] == $past(wr_data[15:0]) :
                             rd_data       == $past(wr_data)));
endmodule

// File: tb/test_bank_regfile.sv
module test_bank_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  acc_size = 2'b00;
  logic [3:0]  acc_idx = 4'h0;
  logic [23:0] wr_data = 24'h0;
  logic        wr_en = 1'b0;
  logic [15:0] status_word = 16'h0;
  logic        compat = 1'b0;
  logic [23:0] rd_data;
  logic        acc_err;

  int n_chk = 0;
  int n_fail = 0;

  bank_regfile i_bank_regfile (
    .clk(clk), .rst_n(rst_n), .acc_size(acc_size), .acc_idx(acc_idx),
    .wr_data(wr_data), .wr_en(wr_en), .status_word(status_word),
    .compat(compat), .rd_data(rd_data), .acc_err(acc_err));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] sz, input logic [3:0] idx,
                       input logic [2:0] bk, input logic cm);
    acc_size = sz; acc_idx = idx; compat = cm;
    status_word = {1'b0, bk, 12'h000};
    #1;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [3:0] idx, input logic [2:0] bk,
                    input logic cm, input logic [23:0] d);
    setup(sz, idx, bk, cm);
    wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] sz, input logic [3:0] idx,
                        input logic [2:0] bk, input logic cm,
                        input logic [23:0] exp, input logic exp_err);
    setup(sz, idx, bk, cm);
    check(req, {acc_err, rd_data}, {exp_err, exp});
  endtask

  task automatic t_reset;
    rd_chk("R1", 2'b00, 4'd0, 3'd0, 1'b0, 24'h0, 1'b0);
    rd_chk("R1", 2'b01, 4'd7, 3'd5, 1'b0, 24'h0, 1'b0);
    rd_chk("R1", 2'b10, 4'd6, 3'd7, 1'b0, 24'h0, 1'b0);
  endtask

  task automatic t_byte;
    wr(2'b00, 4'd5, 3'd0, 1'b0, 24'hFFFF5A);
    rd_chk("R2", 2'b00, 4'd5, 3'd0, 1'b0, 24'h00005A, 1'b0);
    rd_chk("R2", 2'b00, 4'd4, 3'd0, 1'b0, 24'h0, 1'b0);
    rd_chk("R9", 2'b01, 4'd2, 3'd0, 1'b0, 24'h005A00, 1'b0);
  endtask

  task automatic t_pair;
    wr(2'b01, 4'd1, 3'd0, 1'b0, 24'hFF1234);
    rd_chk("R3", 2'b01, 4'd1, 3'd0, 1'b0, 24'h001234, 1'b0);
    rd_chk("R3", 2'b00, 4'd3, 3'd0, 1'b0, 24'h000012, 1'b0);
    rd_chk("R9", 2'b00, 4'd2, 3'd0, 1'b0, 24'h000034, 1'b0);
  endtask

  task automatic t_ext;
    wr(2'b10, 4'd6, 3'd2, 1'b0, 24'hABCDEF);
    rd_chk("R4", 2'b10, 4'd6, 3'd2, 1'b0, 24'hABCDEF, 1'b0);
    rd_chk("R4", 2'b01, 4'd6, 3'd2, 1'b0, 24'h00CDEF, 1'b0);
    rd_chk("R9", 2'b00, 4'd13, 3'd2, 1'b0, 24'h0000CD, 1'b0);
    rd_chk("R4", 2'b10, 4'd7, 3'd2, 1'b0, 24'h0, 1'b0);
    wr(2'b00, 4'd15, 3'd2, 1'b0, 24'h000077);
    rd_chk("R9", 2'b10, 4'd7, 3'd2, 1'b0, 24'h007700, 1'b0);
  endtask

  task automatic t_bank;
    acc_size = 2'b00; acc_idx = 4'd0; compat = 1'b0;
    status_word = 16'hFFFF; wr_data = 24'h0000C3; wr_en = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0;
    status_word = 16'h7000; #1;
    check("R5", {acc_err, rd_data}, {1'b0, 24'h0000C3});
    status_word = 16'h8FFF; #1;
    check("R5", {acc_err, rd_data}, {1'b0, 24'h0});
    rd_chk("R5", 2'b10, 4'd6, 3'd3, 1'b0, 24'h0, 1'b0);
  endtask

  task automatic t_compat;
    wr(2'b00, 4'd4, 3'd1, 1'b1, 24'h000011);
    rd_chk("R6", 2'b00, 4'd0, 3'd1, 1'b0, 24'h000011, 1'b0);
    rd_chk("R6", 2'b00, 4'd4, 3'd1, 1'b0, 24'h0, 1'b0);
    wr(2'b01, 4'd3, 3'd1, 1'b1, 24'h00BEEF);
    rd_chk("R6", 2'b00, 4'd3, 3'd1, 1'b0, 24'h0000BE, 1'b0);
    rd_chk("R6", 2'b01, 4'd2, 3'd1, 1'b1, 24'h000011, 1'b0);
    rd_chk("R6", 2'b00, 4'd7, 3'd1, 1'b1, 24'h0000BE, 1'b0);
    wr(2'b10, 4'd4, 3'd1, 1'b1, 24'h010203);
    rd_chk("R6", 2'b01, 4'd4, 3'd1, 1'b0, 24'h000203, 1'b0);
    rd_chk("R6", 2'b01, 4'd0, 3'd1, 1'b0, 24'h000011, 1'b0);
  endtask

  task automatic t_invalid;
    rd_chk("R7", 2'b01, 4'd9, 3'd4, 1'b0, 24'h0, 1'b1);
    rd_chk("R7", 2'b10, 4'd3, 3'd4, 1'b0, 24'h0, 1'b1);
    rd_chk("R7", 2'b11, 4'd0, 3'd4, 1'b0, 24'h0, 1'b1);
    wr(2'b01, 4'd9, 3'd4, 1'b0, 24'hFFFFFF);
    wr(2'b10, 4'd3, 3'd4, 1'b0, 24'hFFFFFF);
    wr(2'b11, 4'd1, 3'd4, 1'b0, 24'hFFFFFF);
    for (int k = 0; k < 16; k++)
      rd_chk("R7", 2'b00, k[3:0], 3'd4, 1'b0, 24'h0, 1'b0);
    for (int k = 4; k < 8; k++)
      rd_chk("R7", 2'b10, k[3:0], 3'd4, 1'b0, 24'h0, 1'b0);
  endtask

  task automatic t_same_cycle;
    wr(2'b01, 4'd5, 3'd6, 1'b0, 24'h004455);
    setup(2'b01, 4'd5, 3'd6, 1'b0);
    wr_data = 24'h009988; wr_en = 1'b1;
    #1;
    check("R8", {acc_err, rd_data}, {1'b0, 24'h004455});
    @(posedge clk); #1; wr_en = 1'b0;
    check("R8", {acc_err, rd_data}, {1'b0, 24'h009988});
    rd_chk("R8", 2'b01, 4'd5, 3'd5, 1'b0, 24'h0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_byte();
    t_pair();
    t_ext();
    t_bank();
    t_compat();
    t_invalid();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #20000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule